// File: doc/BRIEF.md
# Power management mode controller

This block sets the power state of a small multi-port switch core. A two-bit mode field, held in a register that the host writes, picks one of four global modes. A power-down bit per port can switch that port off in any mode. The block drives enables for the PLL clock, the MAC, the host interface, and, per port, the PHY transmit path, the PHY receive path, the auxiliary receive circuitry and the receive-energy detector.

In the energy-detect mode, the core drops into a deep low-power state when none of the powered ports has a link partner. While in that state it keeps only the energy detectors alive. It also emits a narrow beacon pulse on every powered port once per period. The pulse width and the period come from counters sized from the reference clock frequency. When a powered port sees receive energy, the block returns by itself to the full-power enable pattern. The mode field still reads energy-detect after this wake, so if the link is lost again the block goes back to sleep.

The link and energy inputs are taken as synchronous to `clk`. The mode register accepts writes in every mode, so the host can always leave a low-power mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode field reads 00 and the outputs show the normal-mode pattern.
- R2: A write loads the two-bit field, and the field reads the new value one cycle later. The codes are 00 normal, 01 energy detect, 10 soft power down and 11 power saving. Any mode may be written from any mode.
- R3: In normal mode PLL, MAC and host enables are 1, and PHY transmit, PHY receive and auxiliary receive are 1 on every port whose power-down bit is 0.
- R4: In soft power down mode the PLL, MAC, host, PHY transmit, PHY receive, auxiliary receive, energy detect and beacon outputs are all 0.
- R5: In power saving mode PLL, MAC, host, PHY transmit and PHY receive follow the normal pattern, and auxiliary receive is 0 on every port.
- R6: If the field becomes 01 while no powered port reports link, the block sleeps from the following cycle. While asleep, PLL, MAC, host, PHY transmit, PHY receive and auxiliary receive are 0, and energy detect is 1 on powered ports.
- R7: While asleep, each powered port's beacon goes high at the start of sleep and then once every PERIOD_CYC cycles (CLK_HZ/1e6 × PERIOD_US). Each pulse lasts PULSE_CYC cycles, which is PULSE_NS rounded to the nearest clock period (6 cycles at 50 MHz).
- R8: Receive energy on a powered port while asleep restores the normal enable pattern on the next cycle, and the field still reads 01.
- R9: After such a wake, when the link of the powered ports goes from some up to none, the block sleeps again on the next cycle.
- R10: Entering mode 01 while a powered port has link keeps the normal pattern.
- R11: A port whose power-down bit is 1 has PHY transmit, PHY receive, auxiliary receive, energy detect and beacon at 0 in every mode. Its energy and link inputs are ignored.
- R12: Writing another mode while asleep gives that mode's pattern as soon as the field changes, with no energy detect or beacon left over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_en | input | 1 | Mode field write strobe |
| mode_wr_data | input | 2 | Value to write into the mode field |
| mode_rd | output | 2 | Current mode field |
| port_pd | input | NUM_PORTS | Per-port power-down bits |
| link_up | input | NUM_PORTS | Per-port link status |
| rx_energy | input | NUM_PORTS | Per-port receive energy seen |
| pll_en | output | 1 | PLL clock enable |
| mac_en | output | 1 | MAC enable |
| host_en | output | 1 | Host interface enable |
| phy_tx_en | output | NUM_PORTS | PHY transmit path enables |
| phy_rx_en | output | NUM_PORTS | PHY receive path enables |
| rx_aux_en | output | NUM_PORTS | Auxiliary receive circuitry enables |
| edet_en | output | NUM_PORTS | Receive-energy detector enables |
| beacon | output | NUM_PORTS | Link beacon pulses |

## Verification
A table pairs the three static modes with port power-down masks of none, one, two and all ports. This separates the global enables, which follow the mode only, from the per-port enables, which are masked. The energy-detect mode is driven as a sequence: entry with no link and entry with link show the sleep decision, and the measured pulse width and spacing pin the two counters. Energy on a powered port versus energy on a powered-down port tells a real wake from an ignored one. A link that comes up and then drops shows the relapse into sleep. Writing power saving while asleep shows that no sleep-only output lingers.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_EDET   = 2'b01,
    MODE_SOFTPD = 2'b10,
    MODE_PSAVE  = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic pll;
    logic mac;
    logic host;
    logic phy;
    logic aux;
  } glob_en_t;

  // Nanoseconds to clock cycles, rounded to nearest, at least one cycle.
  function automatic int unsigned ns_to_cycles(longint clk_hz, longint ns);
    longint c;
    c = (ns * clk_hz + 64'sd500_000_000) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // Microseconds to clock cycles, at least two cycles.
  function automatic int unsigned us_to_cycles(longint clk_hz, longint us);
    longint c;
    c = (clk_hz / 64'sd1_000_000) * us;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  // Global enable pattern for a mode and the sleep flag.
  function automatic glob_en_t glob_pattern(pwr_mode_e m, logic sleeping);
    glob_en_t g;
    case (m)
      MODE_NORMAL: g = '{pll: 1'b1, mac: 1'b1, host: 1'b1, phy: 1'b1, aux: 1'b1};
      MODE_EDET:   g = sleeping ? glob_en_t'(5'b0)
                                : '{pll: 1'b1, mac: 1'b1, host: 1'b1, phy: 1'b1, aux: 1'b1};
      MODE_SOFTPD: g = glob_en_t'(5'b0);
      default:     g = '{pll: 1'b1, mac: 1'b1, host: 1'b1, phy: 1'b1, aux: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output pwr_mode_e  mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_NORMAL;
    else if (wr_en) mode_q <= pwr_mode_e'(wr_data);
  end

endmodule

// File: rtl/pwr_edet_fsm.sv
module pwr_edet_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned PULSE_CYC  = 6,
  parameter int unsigned PERIOD_CYC = 50_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pwr_mode_e            mode_q,
  input  logic [NUM_PORTS-1:0] port_pd,
  input  logic [NUM_PORTS-1:0] link_up,
  input  logic [NUM_PORTS-1:0] rx_energy,
  output logic                 sleeping,
  output logic                 wake_evt,
  output logic                 sleep_evt,
  output logic                 pulse
);

  localparam int unsigned CNT_W = $clog2(PERIOD_CYC + 1);

  logic             asleep_q;
  logic             link_prev_q;
  pwr_mode_e        mode_prev_q;
  logic [CNT_W-1:0] cnt_q;

  logic in_ed, ed_enter, any_link, any_energy, link_fell;

  assign in_ed      = (mode_q == MODE_EDET);
  assign ed_enter   = in_ed && (mode_prev_q != MODE_EDET);
  assign any_link   = |(link_up & ~port_pd);
  assign any_energy = |(rx_energy & ~port_pd);
  assign link_fell  = link_prev_q && !any_link;
  assign sleeping   = asleep_q && in_ed;
  assign wake_evt   = sleeping && any_energy;
  assign sleep_evt  = in_ed && !asleep_q && !any_link && (ed_enter || link_fell);
  assign pulse      = sleeping && (cnt_q < CNT_W'(PULSE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q    <= 1'b0;
      link_prev_q <= 1'b0;
      mode_prev_q <= MODE_NORMAL;
    end else begin
      link_prev_q <= any_link;
      mode_prev_q <= mode_q;
      if (!in_ed || wake_evt) asleep_q <= 1'b0;
      else if (sleep_evt)     asleep_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (!sleeping)                      cnt_q <= '0;
    else if (cnt_q == CNT_W'(PERIOD_CYC - 1)) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwr_enable_map.sv
module pwr_enable_map
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  pwr_mode_e            mode_q,
  input  logic                 sleeping,
  input  logic                 pulse,
  input  logic [NUM_PORTS-1:0] port_pd,
  output logic                 pll_en,
  output logic                 mac_en,
  output logic                 host_en,
  output logic [NUM_PORTS-1:0] phy_tx_en,
  output logic [NUM_PORTS-1:0] phy_rx_en,
  output logic [NUM_PORTS-1:0] rx_aux_en,
  output logic [NUM_PORTS-1:0] edet_en,
  output logic [NUM_PORTS-1:0] beacon
);

  glob_en_t g;
  assign g       = glob_pattern(mode_q, sleeping);
  assign pll_en  = g.pll;
  assign mac_en  = g.mac;
  assign host_en = g.host;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic live;
    assign live         = !port_pd[p];
    assign phy_tx_en[p] = g.phy && live;
    assign phy_rx_en[p] = g.phy && live;
    assign rx_aux_en[p] = g.aux && live;
    assign edet_en[p]   = sleeping && live;
    assign beacon[p]    = pulse && live;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter longint      CLK_HZ    = 50_000_000,
  parameter longint      PULSE_NS  = 120,
  parameter longint      PERIOD_US = 1_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr_en,
  input  logic [1:0]           mode_wr_data,
  output logic [1:0]           mode_rd,
  input  logic [NUM_PORTS-1:0] port_pd,
  input  logic [NUM_PORTS-1:0] link_up,
  input  logic [NUM_PORTS-1:0] rx_energy,
  output logic                 pll_en,
  output logic                 mac_en,
  output logic                 host_en,
  output logic [NUM_PORTS-1:0] phy_tx_en,
  output logic [NUM_PORTS-1:0] phy_rx_en,
  output logic [NUM_PORTS-1:0] rx_aux_en,
  output logic [NUM_PORTS-1:0] edet_en,
  output logic [NUM_PORTS-1:0] beacon
);

  localparam int unsigned PULSE_CYC  = ns_to_cycles(CLK_HZ, PULSE_NS);
  localparam int unsigned PERIOD_CYC = us_to_cycles(CLK_HZ, PERIOD_US);

  pwr_mode_e mode_q;
  logic      sleeping, wake_evt, sleep_evt, pulse;

  assign mode_rd = mode_q;

  pwr_mode_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (mode_q)
  );

  pwr_edet_fsm #(
    .NUM_PORTS  (NUM_PORTS),
    .PULSE_CYC  (PULSE_CYC),
    .PERIOD_CYC (PERIOD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .port_pd   (port_pd),
    .link_up   (link_up),
    .rx_energy (rx_energy),
    .sleeping  (sleeping),
    .wake_evt  (wake_evt),
    .sleep_evt (sleep_evt),
    .pulse     (pulse)
  );

  pwr_enable_map #(.NUM_PORTS(NUM_PORTS)) u_map (
    .mode_q    (mode_q),
    .sleeping  (sleeping),
    .pulse     (pulse),
    .port_pd   (port_pd),
    .pll_en    (pll_en),
    .mac_en    (mac_en),
    .host_en   (host_en),
    .phy_tx_en (phy_tx_en),
    .phy_rx_en (phy_rx_en),
    .rx_aux_en (rx_aux_en),
    .edet_en   (edet_en),
    .beacon    (beacon)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PULSE_CYC = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_wr_en,
  input logic [1:0]           mode_wr_data,
  input logic [1:0]           mode_rd,
  input logic [NUM_PORTS-1:0] port_pd,
  input logic                 pll_en,
  input logic                 mac_en,
  input logic                 host_en,
  input logic [NUM_PORTS-1:0] phy_tx_en,
  input logic [NUM_PORTS-1:0] phy_rx_en,
  input logic [NUM_PORTS-1:0] rx_aux_en,
  input logic [NUM_PORTS-1:0] edet_en,
  input logic [NUM_PORTS-1:0] beacon,
  input logic                 wake_evt,
  input logic                 pulse
);

  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (pulse) run_q <= run_q + 1;
    else            run_q <= '0;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> mode_rd == $past(mode_wr_data)); // R2
  AST_NORMAL_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'b00) |-> (pll_en && mac_en && host_en && phy_tx_en == ~port_pd
                            && rx_aux_en == ~port_pd)); // R3
  AST_SOFTPD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'b10) |-> (!pll_en && !mac_en && !host_en && phy_rx_en == '0
                            && edet_en == '0 && beacon == '0)); // R4
  AST_PSAVE_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'b11) |-> (pll_en && rx_aux_en == '0 && phy_rx_en == ~port_pd)); // R5
  AST_BEACON_ASLEEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (beacon != '0) |-> (!pll_en && !host_en && mode_rd == 2'b01)); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse) && !pll_en) |-> run_q == PULSE_CYC); // R7
  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !mode_wr_en) |=> (pll_en && mac_en && mode_rd == 2'b01)); // R8
  AST_PD_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (port_pd & (phy_tx_en | phy_rx_en | rx_aux_en | edet_en | beacon)) == '0); // R11

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .mode_rd      (mode_rd),
  .port_pd      (port_pd),
  .pll_en       (pll_en),
  .mac_en       (mac_en),
  .host_en      (host_en),
  .phy_tx_en    (phy_tx_en),
  .phy_rx_en    (phy_rx_en),
  .rx_aux_en    (rx_aux_en),
  .edet_en      (edet_en),
  .beacon       (beacon),
  .wake_evt     (wake_evt),
  .pulse        (pulse)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

  localparam int NP     = 4;
  localparam int PULSE  = 6;    // 120 ns at 50 MHz
  localparam int PERIOD = 500;  // 10 us at 50 MHz

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr_en = 1'b0;
  logic [1:0]    mode_wr_data = '0;
  logic [1:0]    mode_rd;
  logic [NP-1:0] port_pd = '0, link_up = '0, rx_energy = '0;
  logic          pll_en, mac_en, host_en;
  logic [NP-1:0] phy_tx_en, phy_rx_en, rx_aux_en, edet_en, beacon;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NUM_PORTS(NP), .CLK_HZ(50_000_000), .PULSE_NS(120), .PERIOD_US(10)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .mode_rd(mode_rd), .port_pd(port_pd), .link_up(link_up), .rx_energy(rx_energy),
    .pll_en(pll_en), .mac_en(mac_en), .host_en(host_en), .phy_tx_en(phy_tx_en),
    .phy_rx_en(phy_rx_en), .rx_aux_en(rx_aux_en), .edet_en(edet_en), .beacon(beacon)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode_wr_en = 1'b1; mode_wr_data = m;
    @(negedge clk); mode_wr_en = 1'b0;
  endtask

  // {mode, pd, pll/mac/host, tx, rx, aux}
  typedef struct packed {
    logic [1:0]    mode;
    logic [NP-1:0] pd;
    logic [2:0]    glob;
    logic [NP-1:0] tx, rx, aux;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'b00, 4'b0000, 3'b111, 4'b1111, 4'b1111, 4'b1111},   // R3
    '{2'b00, 4'b0101, 3'b111, 4'b1010, 4'b1010, 4'b1010},   // R3 R11
    '{2'b00, 4'b1111, 3'b111, 4'b0000, 4'b0000, 4'b0000},   // R11
    '{2'b10, 4'b0000, 3'b000, 4'b0000, 4'b0000, 4'b0000},   // R4
    '{2'b10, 4'b0011, 3'b000, 4'b0000, 4'b0000, 4'b0000},   // R4
    '{2'b11, 4'b0000, 3'b111, 4'b1111, 4'b1111, 4'b0000},   // R5
    '{2'b11, 4'b1000, 3'b111, 4'b0111, 4'b0111, 4'b0000},   // R5 R11
    '{2'b00, 4'b0010, 3'b111, 4'b1101, 4'b1101, 4'b1101},   // R2 back to normal
    '{2'b11, 4'b0110, 3'b111, 4'b1001, 4'b1001, 4'b0000}    // R2 R5
  };

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_rd, 2'b00);
    chk("R1 glob", {pll_en, mac_en, host_en}, 3'b111);
    chk("R1 ports", {phy_tx_en, phy_rx_en, rx_aux_en, edet_en, beacon}, {4'hF, 4'hF, 4'hF, 8'h00});

    foreach (VECS[i]) begin
      port_pd = VECS[i].pd;
      write_mode(VECS[i].mode);
      chk("R2 field", mode_rd, VECS[i].mode);
      chk("R3/R4/R5 glob", {pll_en, mac_en, host_en}, VECS[i].glob);
      chk("R3/R4/R5/R11 ports", {phy_tx_en, phy_rx_en, rx_aux_en},
          {VECS[i].tx, VECS[i].rx, VECS[i].aux});
      chk("R11 no edet/beacon", {edet_en, beacon}, 8'h00);
    end

    // R10: enter energy detect with a link up -> stays awake
    port_pd = '0; link_up = 4'b0100;
    write_mode(2'b00);
    write_mode(2'b01);
    repeat (3) @(negedge clk);
    chk("R10 awake", {pll_en, mac_en, host_en, phy_tx_en}, {3'b111, 4'hF});
    chk("R10 no beacon", beacon, 4'h0);
    // R9 from awake: link loss sends it to sleep
    link_up = '0;
    @(negedge clk);
    chk("R9 sleep on link loss", {pll_en, host_en, edet_en}, {2'b00, 4'hF});

    // R6 entry with no link
    write_mode(2'b00);
    write_mode(2'b01);
    chk("R6 awake for one cycle", pll_en, 1'b1);
    @(negedge clk);
    chk("R6 sleep pattern", {pll_en, mac_en, host_en, phy_tx_en, phy_rx_en, rx_aux_en},
        {3'b000, 12'h000});
    chk("R6 edet", edet_en, 4'hF);
    // R7 pulse width and period
    n = 0;
    while (beacon == 4'hF && n < 100) begin n++; @(negedge clk); end
    chk("R7 width", n, PULSE);
    chk("R7 low after pulse", beacon, 4'h0);
    while (beacon == 4'h0 && n < 2000) begin n++; @(negedge clk); end
    chk("R7 period", n, PERIOD);

    // R11: energy on a powered-down port is ignored
    port_pd = 4'b0100; rx_energy = 4'b0100;
    @(negedge clk); @(negedge clk);
    chk("R11 no wake", pll_en, 1'b0);
    chk("R11 edet masked", edet_en, 4'b1011);
    rx_energy = '0; port_pd = '0;

    // R8 wake on energy
    @(negedge clk);
    rx_energy = 4'b0010;
    @(negedge clk);
    rx_energy = '0;
    chk("R8 wake", {pll_en, mac_en, host_en, phy_tx_en, rx_aux_en}, {3'b111, 4'hF, 4'hF});
    chk("R8 field stays", mode_rd, 2'b01);
    chk("R8 edet off", {edet_en, beacon}, 8'h00);
    repeat (4) @(negedge clk);
    chk("R8 stays awake", pll_en, 1'b1);

    // R9 relapse after wake
    link_up = 4'b0010;
    @(negedge clk);
    link_up = '0;
    @(negedge clk);
    chk("R9 relapse", {pll_en, edet_en}, {1'b0, 4'hF});

    // R12 leave sleep by writing power saving
    @(negedge clk); mode_wr_en = 1'b1; mode_wr_data = 2'b11;
    @(negedge clk); mode_wr_en = 1'b0;
    chk("R12 psave pattern", {pll_en, mac_en, host_en, phy_rx_en, rx_aux_en},
        {3'b111, 4'hF, 4'h0});
    chk("R12 no leftovers", {edet_en, beacon}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule